// File: doc/BRIEF.md
# Streaming Two-Error-Correcting Codeword Decoder

This block takes a 15-bit binary BCH codeword (length 15, 7 message bits, corrects up to two errors) as a framed packet on a valid/ready stream. It carries one bit per beat, and the first beat holds the coefficient of x^14. While the bits arrive, two syndromes over GF(16) are built up, with x^4+x+1 as the field polynomial. After the end-of-packet beat the block solves the error locator in closed form in one cycle. It then streams the whole codeword back out, check bits included, under the same start/end framing. The location search runs one position per output beat and flips each bit it identifies as erroneous.

Each output beat also carries the number of errors found and a flag for codewords that cannot be decoded. Both sides honour backpressure. Only one codeword is held at a time, so the input stays stalled from the accepted end-of-packet beat until the last output beat has been taken.

Top module: `bch_stream_decoder`

## Requirements
- R1: A codeword starts on an accepted beat with `in_valid` and `in_sop` high. While no codeword is open, valid beats with `in_sop` low are dropped and have no effect on later output.
- R2: The beat with `in_eop` high ends the codeword, which is 15 beats long. The first accepted bit is the coefficient of x^14. Valid codewords are the multiples of g(x)=x^8+x^7+x^6+x^4+1.
- R3: `in_ready` is high after reset and between codewords. It is low from the cycle after the end-of-packet beat is accepted until the last output beat has been transferred, so it is low on every cycle where `out_valid` is high.
- R4: Each output codeword is exactly 15 transferred beats. `out_sop` is high only on the first of them and `out_eop` only on the last.
- R5: An output beat transfers only when `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_data`, `out_sop` and `out_eop` hold their values.
- R6: The output carries all 15 bits, check bits included, in input order. When a codeword has at most two bit errors, the output equals the original codeword.
- R7: `out_err_count` equals the number of corrected errors (0, 1 or 2). It holds one value across all beats of a codeword, as does `out_uncorrectable`, which is low in these cases.
- R8: `out_uncorrectable` is raised when the codeword cannot be decoded: either S1 is zero and S3 is not, or the locator has fewer roots among the 15 positions than its degree. In that case `out_err_count` is 2 and the data is the received word, unchanged.
- R9: When there are more than two errors and the flag stays low, the output is a valid codeword, and `out_err_count` equals the number of bits that differ from the received word.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Decoder can accept an input beat |
| in_sop | input | 1 | First beat of a codeword |
| in_eop | input | 1 | Last beat of a codeword |
| in_data | input | 1 | Received code bit |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_sop | output | 1 | First output beat of a codeword |
| out_eop | output | 1 | Last output beat of a codeword |
| out_data | output | 1 | Corrected code bit |
| out_err_count | output | 2 | Errors corrected in the codeword being output |
| out_uncorrectable | output | 1 | Codeword could not be decoded |

## Verification
A wrong syndrome or locator value shows up within the same packet. It appears as a bit flipped at the wrong position, a miscount on the first output beat, or a flag raised on a correctable word. For this reason, every pattern of up to two errors is swept over several messages, and every three-error pattern is swept for one message. A mis-stepped search term only shows at the beat where a root was expected, which may be up to 15 beats into the output. A framing or stall fault shows on the very next beat, as a lost or duplicated bit, a misplaced start or end marker, or an input accepted while the output is still draining.

// File: rtl/bchd_pkg.sv
package bchd_pkg;

    localparam int GF_M    = 4;
    localparam int CW_LEN  = (1 << GF_M) - 1;
    localparam int T_CAP   = 2;
    localparam int CNT_W   = $clog2(CW_LEN + 1);
    localparam int ERRC_W  = $clog2(T_CAP + 1);
    localparam int N_SYN   = T_CAP;

    localparam logic [GF_M:0] PRIM_POLY = 5'b10011;

    typedef logic [GF_M-1:0] gf_t;

    localparam gf_t GF_ONE = gf_t'(1);
    localparam gf_t ALPHA1 = gf_t'(2);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_SOLVE,
        ST_SEND
    } dec_state_e;

    typedef struct packed {
        gf_t               sig1;
        gf_t               sig2;
        logic [ERRC_W-1:0] deg;
        logic              fail;
    } locator_t;

    function automatic gf_t gf_mul(gf_t a, gf_t b);
        logic [2*GF_M-2:0] p;
        p = '0;
        for (int i = 0; i < GF_M; i++)
            if (b[i]) p = p ^ ({{(GF_M-1){1'b0}}, a} << i);
        for (int i = 2*GF_M-2; i >= GF_M; i--)
            if (p[i]) p = p ^ ({{(GF_M-2){1'b0}}, PRIM_POLY} << (i - GF_M));
        return p[GF_M-1:0];
    endfunction

    function automatic gf_t gf_pow(gf_t a, int e);
        gf_t r;
        r = GF_ONE;
        for (int i = 0; i < (1 << GF_M); i++)
            if (i < e) r = gf_mul(r, a);
        return r;
    endfunction

    function automatic gf_t gf_inv(gf_t a);
        return gf_pow(a, (1 << GF_M) - 2);
    endfunction

    function automatic logic gf_trace(gf_t a);
        gf_t acc;
        gf_t t;
        acc = '0;
        t   = a;
        for (int i = 0; i < GF_M; i++) begin
            acc = acc ^ t;
            t   = gf_mul(t, t);
        end
        return |acc;
    endfunction

endpackage

// File: rtl/bchd_syndrome.sv
module bchd_syndrome
    import bchd_pkg::*;
#(
    parameter gf_t STEP = ALPHA1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic shift,
    input  logic bit_in,
    output gf_t  syn
);

    gf_t acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (start) begin
            acc_q <= {{(GF_M-1){1'b0}}, bit_in};
        end else if (shift) begin
            acc_q <= gf_mul(acc_q, STEP) ^ {{(GF_M-1){1'b0}}, bit_in};
        end
    end

    assign syn = acc_q;

endmodule

// File: rtl/bchd_locator.sv
module bchd_locator
    import bchd_pkg::*;
(
    input  gf_t      s1,
    input  gf_t      s3,
    output locator_t loc
);

    gf_t s1_sq;
    gf_t s1_cube;
    gf_t s1_inv;
    gf_t disc;
    gf_t sig2_w;

    always_comb begin
        s1_sq   = gf_mul(s1, s1);
        s1_cube = gf_mul(s1_sq, s1);
        s1_inv  = gf_inv(s1);
        disc    = s3 ^ s1_cube;
        sig2_w  = gf_mul(disc, s1_inv);

        loc = '0;
        if (s1 == '0) begin
            if (s3 != '0) begin
                loc.deg  = ERRC_W'(T_CAP);
                loc.fail = 1'b1;
            end
        end else if (disc == '0) begin
            loc.sig1 = s1;
            loc.deg  = ERRC_W'(1);
        end else begin
            loc.sig1 = s1;
            loc.sig2 = sig2_w;
            loc.deg  = ERRC_W'(2);
            loc.fail = gf_trace(gf_mul(sig2_w, gf_inv(s1_sq)));
        end
    end

endmodule

// File: rtl/bchd_chien.sv
module bchd_chien
    import bchd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    input  gf_t  sig1,
    input  gf_t  sig2,
    output logic root
);

    localparam gf_t MUL1 = gf_pow(ALPHA1, 1);
    localparam gf_t MUL2 = gf_pow(ALPHA1, 2);

    gf_t term1_q;
    gf_t term2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            term1_q <= '0;
            term2_q <= '0;
        end else if (load) begin
            term1_q <= gf_mul(sig1, MUL1);
            term2_q <= gf_mul(sig2, MUL2);
        end else if (step) begin
            term1_q <= gf_mul(term1_q, MUL1);
            term2_q <= gf_mul(term2_q, MUL2);
        end
    end

    assign root = ((term1_q ^ term2_q) == GF_ONE);

endmodule

// File: rtl/bch_stream_decoder.sv
module bch_stream_decoder
    import bchd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_data,
    output logic [ERRC_W-1:0] out_err_count,
    output logic              out_uncorrectable
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(CW_LEN - 1);

    dec_state_e        state_q;
    logic [CW_LEN-1:0] word_q;
    logic [CNT_W-1:0]  pos_q;
    logic [CNT_W-1:0]  flips_q;
    locator_t          loc_w;
    locator_t          loc_q;
    gf_t               syn [N_SYN];
    logic              accept;
    logic              syn_start;
    logic              syn_shift;
    logic              beat_out;
    logic              root_w;
    logic              flip_w;

    assign in_ready  = (state_q == ST_IDLE) || (state_q == ST_RECV);
    assign accept    = in_valid && in_ready;
    assign syn_start = accept && in_sop;
    assign syn_shift = accept && !in_sop && (state_q == ST_RECV);

    for (genvar j = 0; j < N_SYN; j++) begin : g_syn
        bchd_syndrome #(
            .STEP(gf_pow(ALPHA1, 2*j + 1))
        ) u_syn (
            .clk   (clk),
            .rst   (rst),
            .start (syn_start),
            .shift (syn_shift),
            .bit_in(in_data),
            .syn   (syn[j])
        );
    end

    bchd_locator u_loc (
        .s1 (syn[0]),
        .s3 (syn[1]),
        .loc(loc_w)
    );

    bchd_chien u_chien (
        .clk (clk),
        .rst (rst),
        .load(state_q == ST_SOLVE),
        .step(beat_out),
        .sig1(loc_w.sig1),
        .sig2(loc_w.sig2),
        .root(root_w)
    );

    assign out_valid         = (state_q == ST_SEND);
    assign beat_out          = out_valid && out_ready;
    assign flip_w            = root_w && !loc_q.fail;
    assign out_sop           = out_valid && (pos_q == '0);
    assign out_eop           = out_valid && (pos_q == LAST_POS);
    assign out_data          = word_q[CW_LEN-1] ^ flip_w;
    assign out_err_count     = loc_q.deg;
    assign out_uncorrectable = loc_q.fail;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            pos_q   <= '0;
            loc_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept && in_sop) begin
                        word_q  <= {{(CW_LEN-1){1'b0}}, in_data};
                        state_q <= in_eop ? ST_SOLVE : ST_RECV;
                    end
                end
                ST_RECV: begin
                    if (accept) begin
                        if (in_sop) word_q <= {{(CW_LEN-1){1'b0}}, in_data};
                        else        word_q <= {word_q[CW_LEN-2:0], in_data};
                        if (in_eop) state_q <= ST_SOLVE;
                    end
                end
                ST_SOLVE: begin
                    loc_q   <= loc_w;
                    pos_q   <= '0;
                    state_q <= ST_SEND;
                end
                ST_SEND: begin
                    if (out_ready) begin
                        word_q <= {word_q[CW_LEN-2:0], 1'b0};
                        pos_q  <= pos_q + 1'b1;
                        if (pos_q == LAST_POS) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || state_q == ST_SOLVE) flips_q <= '0;
        else if (beat_out && flip_w)    flips_q <= flips_q + 1'b1;
    end

    AST_READY_WHILE_SENDING: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R3

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_sop) && $stable(out_eop))); // R5

    AST_SOP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (out_sop && out_ready) |=> !out_sop); // R4

    AST_STATUS_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_sop) |-> ($stable(out_err_count) && $stable(out_uncorrectable))); // R7

    AST_FLIP_TOTAL: assert property (@(posedge clk) disable iff (rst)
        (beat_out && out_eop && !out_uncorrectable)
            |-> ((flips_q + CNT_W'(flip_w)) == CNT_W'(out_err_count))); // R6

    AST_FAIL_COUNT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_uncorrectable) |-> (out_err_count == ERRC_W'(T_CAP))); // R8

endmodule

// File: tb/tb_bch_stream_decoder.sv
module tb_bch_stream_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_ready, in_sop, in_eop, in_data;
    logic       out_valid, out_ready, out_sop, out_eop, out_data;
    logic [1:0] out_err_count;
    logic       out_uncorrectable;

    int checks = 0;
    int errors = 0;

    logic [14:0] exp_rx;
    logic [14:0] exp_cw;
    int          exp_nerr;
    int          rx_count = 0;

    int          beat_idx = 0;
    logic [14:0] got_word;
    logic [1:0]  got_cnt;
    logic        got_flag;
    logic        prev_stall = 1'b0;
    logic        prev_data, prev_sop, prev_eop;

    always #(CLK_PERIOD/2) clk = ~clk;

    bch_stream_decoder dut (
        .clk              (clk),
        .rst              (rst),
        .in_valid         (in_valid),
        .in_ready         (in_ready),
        .in_sop           (in_sop),
        .in_eop           (in_eop),
        .in_data          (in_data),
        .out_valid        (out_valid),
        .out_ready        (out_ready),
        .out_sop          (out_sop),
        .out_eop          (out_eop),
        .out_data         (out_data),
        .out_err_count    (out_err_count),
        .out_uncorrectable(out_uncorrectable)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (time %0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] cw_rem(logic [14:0] w);
        logic [14:0] r;
        r = w;
        for (int i = 14; i >= 8; i--)
            if (r[i]) r = r ^ (15'h1D1 << (i - 8));
        return r[7:0];
    endfunction

    function automatic logic [14:0] encode(logic [6:0] msg);
        logic [14:0] sh;
        sh = {msg, 8'h00};
        return sh | {7'h00, cw_rem(sh)};
    endfunction

    always @(negedge clk) begin
        out_ready = ($urandom % 3) != 0;
        if (!rst && out_valid) begin
            if (prev_stall) begin
                chk(out_data == prev_data, "R5 data hold", out_data, prev_data);
                chk({out_sop, out_eop} == {prev_sop, prev_eop}, "R5 framing hold",
                    {out_sop, out_eop}, {prev_sop, prev_eop});
            end
            prev_stall = !out_ready;
            prev_data  = out_data;
            prev_sop   = out_sop;
            prev_eop   = out_eop;
            if (out_ready) begin
                chk(!in_ready, "R3 ready low while sending", in_ready, 0);
                chk(out_sop == (beat_idx == 0), "R4 sop position", out_sop, beat_idx == 0);
                chk(out_eop == (beat_idx == 14), "R4 eop position", out_eop, beat_idx == 14);
                got_word[14 - beat_idx] = out_data;
                if (beat_idx == 0) begin
                    got_cnt  = out_err_count;
                    got_flag = out_uncorrectable;
                end else begin
                    chk({out_err_count, out_uncorrectable} == {got_cnt, got_flag},
                        "R7 status held across packet", {out_err_count, out_uncorrectable},
                        {got_cnt, got_flag});
                end
                if (beat_idx == 14) begin
                    if (exp_nerr <= 2) begin
                        chk(got_word == exp_cw, "R6 corrected word", got_word, exp_cw);
                        chk(got_cnt == 2'(exp_nerr), "R7 error count", got_cnt, exp_nerr);
                        chk(!got_flag, "R7 flag low when correctable", got_flag, 0);
                    end else if (got_flag) begin
                        chk(got_word == exp_rx, "R8 data passed unchanged", got_word, exp_rx);
                        chk(got_cnt == 2'd2, "R8 count on failure", got_cnt, 2);
                    end else begin
                        chk(cw_rem(got_word) == 8'h00, "R9 output is a codeword",
                            cw_rem(got_word), 0);
                        chk(32'(got_cnt) == $countones(got_word ^ exp_rx) && got_cnt != 0,
                            "R9 count equals distance", got_cnt, $countones(got_word ^ exp_rx));
                    end
                    beat_idx = 0;
                    rx_count++;
                end else begin
                    beat_idx++;
                end
            end
        end else begin
            prev_stall = 1'b0;
        end
    end

    task automatic send_word(input logic [14:0] w);
        int b;
        b = 0;
        while (b < 15) begin
            @(negedge clk);
            if (($urandom % 4) == 0) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_data  = w[14 - b];
                in_sop   = (b == 0);
                in_eop   = (b == 14);
                if (in_ready) b++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    task automatic run_case(input logic [6:0] msg, input logic [14:0] err);
        int target;
        exp_cw   = encode(msg);
        exp_rx   = exp_cw ^ err;
        exp_nerr = $countones(err);
        target   = rx_count + 1;
        send_word(exp_rx);
        while (rx_count < target) @(negedge clk);
        @(negedge clk);
        chk(in_ready, "R3 ready high between codewords", in_ready, 1);
    endtask

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
        in_data  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R10 out_valid after reset", out_valid, 0);
        chk(in_ready, "R10 in_ready after reset", in_ready, 1);

        // R1: stray beats without start marker are dropped
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = 1'b0;
            in_eop   = (k == 3);
            in_data  = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_eop   = 1'b0;
        chk(!out_valid, "R1 stray beats produce no output", out_valid, 0);
        run_case(7'h2B, 15'h0000);
        run_case(7'h2B, 15'h0401);

        // R2 R6 R7: every pattern of zero, one and two errors
        for (int m = 0; m < 3; m++) begin
            logic [6:0] msg;
            msg = (m == 0) ? 7'h00 : (m == 1) ? 7'h5A : 7'h7F;
            run_case(msg, 15'h0000);
            for (int i = 0; i < 15; i++) begin
                run_case(msg, 15'(1) << i);
                for (int j = i + 1; j < 15; j++)
                    run_case(msg, (15'(1) << i) | (15'(1) << j));
            end
        end

        // R8 R9: every pattern of three errors
        for (int i = 0; i < 15; i++)
            for (int j = i + 1; j < 15; j++)
                for (int k = j + 1; k < 15; k++)
                    run_case(7'h35, (15'(1) << i) | (15'(1) << j) | (15'(1) << k));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule